// File: doc/BRIEF.md
# CAN Message Memory Access Gate

This block sits between a CPU register bus and the word-organised storage of a CAN controller. Each request carries a byte address, a write flag, four byte enables and write data. The address is sorted into a small control-register window, a message-buffer window, a gap of buffer slots that do not physically exist, a receive-mask window with one word per buffer, and reserved space. Legal requests reach a single internal RAM. Every request gets a one-cycle ready strobe on the next clock, together with an error flag. A faulting request never touches storage and returns zero data.

A programmable last-active-buffer index splits the implemented buffers in two. Buffers at or below the index, their mask words, and the control words are live controller state, and only full-word accesses are accepted there. Buffers above the index, and the mask words that belong to them, act as scratch RAM at byte, halfword or word size. The block has no interlock against scratch use while the controller is sending or receiving frames. Software must not use the unused buffer area as RAM while frames are on the bus.

Byte map with default parameters: control words at 0x000-0x01F; reserved space at 0x020-0x07F; 64 buffers of 16 bytes at 0x080-0x47F; unimplemented buffer slots at 0x480-0x87F; mask words at 0x880-0x97F; reserved space from 0x980 to the top of the 4 KB window.

Top module: `can_mb_access`

## Requirements
- R1: While reset is held and after it is released, with no request, rdy_o, err_o and rdata_o are all 0.
- R2: A request sampled at a clock edge produces rdy_o = 1 for exactly the next cycle. rdy_o is 0 in a cycle that follows no request. err_o is only ever 1 together with rdy_o.
- R3: A request faults (err_o = 1) if addr_i[1:0] is not 0, or if be_i is not one of 0001, 0010, 0100, 1000, 0011, 1100, 1111, where bit n enables data byte n (bits 8n+7:8n).
- R4: Requests to reserved space (0x020-0x07F, and 0x980 and above) fault.
- R5: Requests to unimplemented buffer slots (0x480-0x87F) fault.
- R6: Control words, buffers with index at most last_idx_i, and mask words with index at most last_idx_i accept only be_i = 1111. Any other enable pattern faults there.
- R7: Buffers with index above last_idx_i (buffer n starts at 0x080 + 16n), and mask words with index above last_idx_i (mask n at 0x880 + 4n), accept byte, aligned halfword and word accesses. A write changes only the enabled bytes.
- R8: A faulting write leaves every storage word unchanged.
- R9: A read that does not fault returns the full 32-bit stored word on rdata_o with its ready strobe. A faulting response returns rdata_o = 0.
- R10: Changing last_idx_i changes which sizes are legal at an address, but does not alter any stored contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte address inside the controller window |
| be_i | input | 4 | Byte enables, bit n selects data byte n |
| wdata_i | input | 32 | Write data |
| last_idx_i | input | 6 | Index of the last live message buffer |
| rdy_o | output | 1 | Response strobe, one cycle after the request |
| err_o | output | 1 | Access error, valid with rdy_o |
| rdata_o | output | 32 | Read data, valid with rdy_o, zero on error |

## Verification
The assertions assume that req_i, we_i, addr_i and be_i carry known values in every cycle after reset. They also assume that last_idx_i does not change in the cycle a request is sampled, so that the response relates only to the request one edge earlier. The bench drives all inputs at the falling clock edge and holds last_idx_i still while a request is pending. It changes the index only in idle cycles between accesses. The random addresses are drawn per region, so the gap, reserved, live and scratch spaces are all exercised under several index values.

// File: rtl/can_mb_pkg.sv
package can_mb_pkg;

  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;

  typedef enum logic [2:0] {
    RG_CTRL,
    RG_RSVD,
    RG_BUF,
    RG_GAP,
    RG_MASK
  } region_e;

endpackage

// File: rtl/can_mb_lanes.sv
module can_mb_lanes #(
  parameter int LANES = 4
) (
  input  logic [LANES-1:0]   be_i,
  output logic               legal_o,
  output logic               full_o,
  output logic [8*LANES-1:0] bitmask_o
);

  // expand each byte enable into a byte-wide write mask
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign bitmask_o[8*g +: 8] = {8{be_i[g]}};
  end

  assign full_o = &be_i;

  // legal: a naturally aligned group of 1, 2, 4 ... lanes
  always_comb begin
    legal_o = 1'b0;
    for (int s = 1; s <= LANES; s = s * 2) begin
      for (int o = 0; o < LANES; o = o + s) begin
        if (be_i == LANES'(((1 << s) - 1) << o)) legal_o = 1'b1;
      end
    end
  end

endmodule

// File: rtl/can_mb_decode.sv
module can_mb_decode
  import can_mb_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int NUM_BUF    = 64,
  parameter int BUF_BYTES  = 16,
  parameter int CTRL_WORDS = 8,
  parameter int BUF_BASE   = 'h080,
  parameter int MASK_BASE  = 'h880,
  parameter int IDX_W      = 6,
  parameter int RIDX_W     = 9
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [IDX_W-1:0]  last_idx_i,
  output region_e           region_o,
  output logic              active_o,
  output logic [RIDX_W-1:0] widx_o
);

  localparam int CTRL_END   = CTRL_WORDS * 4;
  localparam int BUF_END    = BUF_BASE + NUM_BUF * BUF_BYTES;
  localparam int MASK_END   = MASK_BASE + NUM_BUF * 4;
  localparam int BUF_SH     = $clog2(BUF_BYTES);
  localparam int MASK_WORD0 = CTRL_WORDS + NUM_BUF * BUF_BYTES / 4;

  logic [ADDR_W-1:0] buf_off, mask_off, buf_num, mask_num, last_ext;

  always_comb begin
    buf_off  = addr_i - ADDR_W'(BUF_BASE);
    mask_off = addr_i - ADDR_W'(MASK_BASE);
    buf_num  = buf_off >> BUF_SH;
    mask_num = mask_off >> 2;
    last_ext = ADDR_W'(last_idx_i);
    region_o = RG_RSVD;
    active_o = 1'b0;
    widx_o   = '0;
    if (addr_i < ADDR_W'(CTRL_END)) begin
      region_o = RG_CTRL;
      active_o = 1'b1;
      widx_o   = RIDX_W'(addr_i >> 2);
    end else if (addr_i < ADDR_W'(BUF_BASE)) begin
      region_o = RG_RSVD;
    end else if (addr_i < ADDR_W'(BUF_END)) begin
      region_o = RG_BUF;
      active_o = (buf_num <= last_ext);
      widx_o   = RIDX_W'(buf_off >> 2) + RIDX_W'(CTRL_WORDS);
    end else if (addr_i < ADDR_W'(MASK_BASE)) begin
      region_o = RG_GAP;
    end else if (addr_i < ADDR_W'(MASK_END)) begin
      region_o = RG_MASK;
      active_o = (mask_num <= last_ext);
      widx_o   = RIDX_W'(mask_num) + RIDX_W'(MASK_WORD0);
    end
  end

endmodule

// File: rtl/can_mb_ram.sv
module can_mb_ram #(
  parameter int WORDS  = 328,
  parameter int DATA_W = 32,
  parameter int RIDX_W = 9
) (
  input  logic              clk_i,
  input  logic              wen_i,
  input  logic              ren_i,
  input  logic [RIDX_W-1:0] idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] bitmask_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk_i) begin
    if (wen_i) begin
      mem[idx_i] <= (mem[idx_i] & ~bitmask_i) | (wdata_i & bitmask_i);
    end
    if (ren_i) begin
      rdata_o <= mem[idx_i];
    end
  end

endmodule

// File: rtl/can_mb_access.sv
module can_mb_access
  import can_mb_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int NUM_BUF    = 64,
  parameter int BUF_BYTES  = 16,
  parameter int CTRL_WORDS = 8,
  parameter int BUF_BASE   = 'h080,
  parameter int MASK_BASE  = 'h880,
  parameter int IDX_W      = $clog2(NUM_BUF)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANES-1:0]  be_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  last_idx_i,
  output logic              rdy_o,
  output logic              err_o,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int WORDS    = CTRL_WORDS + NUM_BUF * BUF_BYTES / 4 + NUM_BUF;
  localparam int RIDX_W   = $clog2(WORDS);
  localparam int CTRL_END = CTRL_WORDS * 4;
  localparam int BUF_END  = BUF_BASE + NUM_BUF * BUF_BYTES;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  region_e           region;
  logic              active, be_legal, be_full, fault;
  logic              ram_wen, ram_ren;
  logic [RIDX_W-1:0] widx;
  logic [DATA_W-1:0] bitmask, ram_q;

  can_mb_lanes #(.LANES(LANES)) i_lanes (
    .be_i      (be_i),
    .legal_o   (be_legal),
    .full_o    (be_full),
    .bitmask_o (bitmask)
  );

  can_mb_decode #(
    .ADDR_W(ADDR_W), .NUM_BUF(NUM_BUF), .BUF_BYTES(BUF_BYTES),
    .CTRL_WORDS(CTRL_WORDS), .BUF_BASE(BUF_BASE), .MASK_BASE(MASK_BASE),
    .IDX_W(IDX_W), .RIDX_W(RIDX_W)
  ) i_decode (
    .addr_i     (addr_i),
    .last_idx_i (last_idx_i),
    .region_o   (region),
    .active_o   (active),
    .widx_o     (widx)
  );

  always_comb begin
    fault = (addr_i[1:0] != 2'b00) || !be_legal
         || (region == RG_RSVD) || (region == RG_GAP)
         || (active && !be_full);
    ram_wen = req_i && we_i && !fault;
    ram_ren = req_i && !we_i && !fault;
  end

  can_mb_ram #(.WORDS(WORDS), .DATA_W(DATA_W), .RIDX_W(RIDX_W)) i_ram (
    .clk_i     (clk_i),
    .wen_i     (ram_wen),
    .ren_i     (ram_ren),
    .idx_i     (widx),
    .wdata_i   (wdata_i),
    .bitmask_i (bitmask),
    .rdata_o   (ram_q)
  );

  // response registers
  logic rdy_d, err_d, rd_d, rdy_q, err_q, rd_q;

  always_comb begin
    rdy_d = req_i;
    err_d = req_i && fault;
    rd_d  = ram_ren;
  end

  always_ff @(posedge clk_i or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      rdy_q <= 1'b0;
      err_q <= 1'b0;
      rd_q  <= 1'b0;
    end else begin
      rdy_q <= rdy_d;
      err_q <= err_d;
      rd_q  <= rd_d;
    end
  end

  assign rdy_o   = rdy_q;
  assign err_o   = err_q;
  assign rdata_o = rd_q ? ram_q : '0;

  AST_RSP_NEXT_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    req_i |=> rdy_o); // R2
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    !req_i |=> !rdy_o); // R2
  AST_ERR_WITH_RDY: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    err_o |-> rdy_o); // R2
  AST_MISALIGN_FAULT: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    (req_i && addr_i[1:0] != 2'b00) |=> err_o); // R3
  AST_GAP_FAULT: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    (req_i && addr_i >= ADDR_W'(BUF_END) && addr_i < ADDR_W'(MASK_BASE)) |=> err_o); // R5
  AST_CTRL_FULL_ONLY: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    (req_i && addr_i < ADDR_W'(CTRL_END) && be_i != '1) |=> err_o); // R6
  AST_ERR_DATA_ZERO: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    err_o |-> (rdata_o == '0)); // R9

endmodule

// File: tb/test_can_mb_access.sv
module test_can_mb_access;

  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, req, we;
  logic [11:0] addr;
  logic [3:0]  be;
  logic [31:0] wdata;
  logic [5:0]  last_idx;
  logic        rdy, err;
  logic [31:0] rdata;

  int checks = 0;
  int failures = 0;

  logic [31:0] shadow [1024];
  logic [3:0]  known  [1024];

  can_mb_access i_can_mb_access (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .be_i(be), .wdata_i(wdata), .last_idx_i(last_idx),
    .rdy_o(rdy), .err_o(err), .rdata_o(rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic legal_be(input logic [3:0] b);
    return b == 4'b0001 || b == 4'b0010 || b == 4'b0100 || b == 4'b1000 ||
           b == 4'b0011 || b == 4'b1100 || b == 4'b1111;
  endfunction

  function automatic logic exp_fault(input logic [11:0] a, input logic [3:0] b,
                                     input logic [5:0] mx);
    logic live;
    if (a[1:0] != 2'b00) return 1'b1;
    if (!legal_be(b)) return 1'b1;
    if (a < 12'h020) live = 1'b1;
    else if (a < 12'h080) return 1'b1;
    else if (a < 12'h480) live = ((a - 12'h080) >> 4) <= 12'(mx);
    else if (a < 12'h880) return 1'b1;
    else if (a < 12'h980) live = ((a - 12'h880) >> 2) <= 12'(mx);
    else return 1'b1;
    return live && (b != 4'hF);
  endfunction

  function automatic logic [31:0] lane_mask(input logic [3:0] b);
    return {{8{b[3]}}, {8{b[2]}}, {8{b[1]}}, {8{b[0]}}};
  endfunction

  task automatic check(input logic ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [11:0] a, input logic [3:0] b,
                        input logic [31:0] d, input string tag);
    logic ef;
    logic [31:0] m;
    int wi;
    @(negedge clk);
    check(rdy == 1'b0, "R2", "idle rdy", {31'b0, rdy}, 32'd0);
    req = 1'b1; we = w; addr = a; be = b; wdata = d;
    ef = exp_fault(a, b, last_idx);
    wi = int'(a >> 2);
    @(negedge clk);
    req = 1'b0;
    check(rdy == 1'b1 && err == ef, tag, "rdy/err", {30'b0, rdy, err}, {30'b0, 1'b1, ef});
    if (ef) begin
      check(rdata == 32'd0, "R9", "rdata on error", rdata, 32'd0);
    end else if (w) begin
      m = lane_mask(b);
      shadow[wi] = (shadow[wi] & ~m) | (d & m);
      known[wi]  = known[wi] | b;
    end else begin
      m = lane_mask(known[wi]);
      check((rdata & m) == (shadow[wi] & m), tag, "read data", rdata & m, shadow[wi] & m);
    end
  endtask

  task automatic set_idx(input logic [5:0] v);
    @(negedge clk);
    last_idx = v;
  endtask

  function automatic logic [11:0] rand_addr();
    case ($urandom % 8)
      0:       return 12'(($urandom % 8) * 4);
      1:       return 12'h020 + 12'(($urandom % 24) * 4);
      2, 3:    return 12'h080 + 12'(($urandom % 256) * 4);
      4:       return 12'h480 + 12'(($urandom % 256) * 4);
      5, 6:    return 12'h880 + 12'(($urandom % 64) * 4);
      default: return 12'($urandom);
    endcase
  endfunction

  function automatic logic [3:0] rand_be();
    logic [3:0] pick [7] = '{4'h1, 4'h2, 4'h4, 4'h8, 4'h3, 4'hC, 4'hF};
    if ($urandom % 8 == 0) return 4'($urandom);
    return pick[$urandom % 7];
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 1024; i++) begin
      shadow[i] = '0;
      known[i]  = '0;
    end
    rst_n = 1'b0; req = 1'b0; we = 1'b0; addr = '0; be = '0; wdata = '0;
    last_idx = 6'd10;
    repeat (3) @(negedge clk);
    check(rdy == 0 && err == 0 && rdata == 0, "R1", "in reset", {rdy, err, rdata[29:0]}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(rdy == 0 && err == 0 && rdata == 0, "R1", "after reset", {rdy, err, rdata[29:0]}, 32'd0);

    // scratch mask word 20 (index 10 is last live)
    access(1'b1, 12'h8D0, 4'hF, 32'hA5A5_1234, "R7");
    access(1'b1, 12'h8D0, 4'h4, 32'h00EE_0000, "R7");
    access(1'b0, 12'h8D0, 4'hF, 32'h0,         "R9");
    check(rdata == 32'hA5EE_1234, "R7", "byte lane merge", rdata, 32'hA5EE_1234);
    // scratch buffer 63 halfword
    access(1'b1, 12'h470, 4'h3, 32'h5555_BEEF, "R7");
    access(1'b0, 12'h470, 4'h3, 32'h0,         "R7");
    // live buffer 3
    access(1'b1, 12'h0B0, 4'hF, 32'h1122_3344, "R6");
    access(1'b1, 12'h0B0, 4'h1, 32'hFFFF_FFFF, "R6");
    access(1'b0, 12'h0B0, 4'hF, 32'h0,         "R8");
    check(rdata == 32'h1122_3344, "R8", "faulting write kept word", rdata, 32'h1122_3344);
    access(1'b1, 12'h004, 4'hC, 32'h0,         "R6");
    // alignment and enables
    access(1'b0, 12'h0B2, 4'hF, 32'h0,         "R3");
    access(1'b1, 12'h8D0, 4'h5, 32'h0,         "R3");
    access(1'b1, 12'h8D0, 4'h6, 32'h0,         "R3");
    // reserved and gap
    access(1'b1, 12'h040, 4'hF, 32'h0,         "R4");
    access(1'b0, 12'h980, 4'hF, 32'h0,         "R4");
    access(1'b0, 12'hFFC, 4'hF, 32'h0,         "R4");
    access(1'b1, 12'h500, 4'hF, 32'h0,         "R5");
    access(1'b0, 12'h87C, 4'hF, 32'h0,         "R5");
    // raising the live index
    set_idx(6'd63);
    access(1'b1, 12'h8D0, 4'h1, 32'h0000_0077, "R10");
    access(1'b0, 12'h8D0, 4'hF, 32'h0,         "R10");
    check(rdata == 32'hA5EE_1234, "R10", "contents kept", rdata, 32'hA5EE_1234);

    // random phase
    for (int ph = 0; ph < 6; ph++) begin
      set_idx(6'($urandom));
      for (int n = 0; n < 120; n++) begin
        access(1'($urandom), rand_addr(), rand_be(), $urandom, "R7");
      end
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule